// File: doc/BRIEF.md
# Rate-Compensated Available Charge Tracker

This block holds two charge registers for a battery monitor. The first register is the compensated available charge. While the battery discharges, it tracks a rate-compensated estimate that an upstream stage computes. While the battery charges, it follows the raw available charge. The second register is a temperature-derated copy of the first. A gauge or display stage reads this copy to report how much charge is usable under present conditions.

Each update arrives as one beat on a valid/ready input. A beat carries:
- the raw available charge,
- the rate-compensated value,
- the direction (charge or discharge),
- a cold-battery indication,
- a derating amount.

`upd_ready` is held high at all times, so the block never applies back-pressure. A beat transfers on every rising clock edge where `upd_valid` is high. The upstream source may drop `upd_valid` for any number of cycles, and both registers hold while it is low. Both outputs are registered and change on the edge that accepts a beat.

During discharge, the compensated register never rises. It takes the rate-compensated value only when that value is strictly below its present contents. This keeps a fast-draining battery from appearing to recover when the rate falls. At high discharge rates the rate-compensated value sits below the raw charge, and the register follows it down.

Top module: `chg_trk_top`

## Requirements
- R1: While `rst` is high, both `comp_chg` and `temp_chg` load `raw_chg` on every clock edge.
- R2: On an edge with `upd_valid` low (and `rst` low), both `comp_chg` and `temp_chg` keep their values.
- R3: On an accepted beat with `chg_mode` = 0 (discharge) and `rate_chg` < `comp_chg`, `comp_chg` becomes `rate_chg`.
- R4: On an accepted beat with `chg_mode` = 0 and `rate_chg` >= `comp_chg` (including equality), `comp_chg` is unchanged.
- R5: Across any accepted discharge beat, `comp_chg` never increases.
- R6: On an accepted beat with `chg_mode` = 1 (charge), `comp_chg` becomes `raw_chg`, whether that value is higher or lower.
- R7: On an accepted beat with `cold` = 0, `temp_chg` becomes the new value of `comp_chg`.
- R8: On an accepted beat with `cold` = 1 and `derate` below the new `comp_chg`, `temp_chg` becomes the new `comp_chg` minus `derate`.
- R9: On an accepted beat with `cold` = 1 and `derate` >= the new `comp_chg`, `temp_chg` becomes 0.
- R10: Outside reset, `temp_chg` never exceeds `comp_chg`.
- R11: `upd_ready` is 1 in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| upd_valid | input | 1 | Update beat present |
| upd_ready | output | 1 | Always 1; a beat transfers whenever valid is high |
| chg_mode | input | 1 | Beat direction: 1 = charge, 0 = discharge |
| cold | input | 1 | Battery below the cold threshold |
| raw_chg | input | CHG_W | Raw available charge |
| rate_chg | input | CHG_W | Rate-compensated available charge |
| derate | input | CHG_W | Cold derating amount |
| comp_chg | output | CHG_W | Compensated available charge register |
| temp_chg | output | CHG_W | Temperature-derated copy |

## Verification
The hardest situation to reach is a discharge beat whose rate value equals the register exactly. That beat must be ignored. Random 16-bit values almost never land on it, so a directed beat drives `rate_chg` equal to the current contents, and the random phase draws rate values from a narrow window around the register's value. Cold beats whose derating equals or exceeds the new compensated value are forced in the same way. This covers the floor at zero and the boundary where the difference is exactly zero. The random phase also mixes long discharge runs with charge beats, which step the register back up so that the downward-only rule is exercised many times.

// File: rtl/chg_trk_pkg.sv
package chg_trk_pkg;
  typedef enum logic {
    DIR_DISCHARGE = 1'b0,
    DIR_CHARGE    = 1'b1
  } dir_e;
endpackage

// File: rtl/chg_trk_comp.sv
module chg_trk_comp
  import chg_trk_pkg::*;
#(
  parameter int CHG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  dir_e             dir,
  input  logic [CHG_W-1:0] raw,
  input  logic [CHG_W-1:0] rate,
  output logic [CHG_W-1:0] comp_q,
  output logic [CHG_W-1:0] comp_nxt
);
  logic rate_lower;

  assign rate_lower = (rate < comp_q);

  always_comb begin
    comp_nxt = comp_q;
    if (fire) begin
      if (dir == DIR_CHARGE) comp_nxt = raw;
      else if (rate_lower)   comp_nxt = rate;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) comp_q <= raw;
    else     comp_q <= comp_nxt;
  end

  a_r5_disch_nonincr: assert property (@(posedge clk) disable iff (rst)
    (fire && dir == DIR_DISCHARGE) |=> (comp_q <= $past(comp_q)));

  a_r3_disch_lower_loads: assert property (@(posedge clk) disable iff (rst)
    (fire && dir == DIR_DISCHARGE && rate < comp_q) |=> (comp_q == $past(rate)));

  a_r6_charge_tracks_raw: assert property (@(posedge clk) disable iff (rst)
    (fire && dir == DIR_CHARGE) |=> (comp_q == $past(raw)));

  a_r2_comp_hold: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(comp_q));
endmodule

// File: rtl/chg_trk_temp.sv
module chg_trk_temp #(
  parameter int CHG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic             cold,
  input  logic [CHG_W-1:0] raw,
  input  logic [CHG_W-1:0] comp_nxt,
  input  logic [CHG_W-1:0] derate,
  output logic [CHG_W-1:0] temp_q
);
  localparam logic [CHG_W-1:0] ZERO = '0;

  logic [CHG_W-1:0] derated;
  logic [CHG_W-1:0] load_val;

  always_comb begin
    if (derate >= comp_nxt) derated = ZERO;
    else                    derated = comp_nxt - derate;
    load_val = cold ? derated : comp_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst)       temp_q <= raw;
    else if (fire) temp_q <= load_val;
  end

  a_r2_temp_hold: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(temp_q));

  a_r9_floor_zero: assert property (@(posedge clk) disable iff (rst)
    (fire && cold && derate >= comp_nxt) |=> (temp_q == ZERO));
endmodule

// File: rtl/chg_trk_top.sv
module chg_trk_top
  import chg_trk_pkg::*;
#(
  parameter int CHG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_valid,
  output logic             upd_ready,
  input  logic             chg_mode,
  input  logic             cold,
  input  logic [CHG_W-1:0] raw_chg,
  input  logic [CHG_W-1:0] rate_chg,
  input  logic [CHG_W-1:0] derate,
  output logic [CHG_W-1:0] comp_chg,
  output logic [CHG_W-1:0] temp_chg
);
  logic             fire;
  dir_e             dir;
  logic [CHG_W-1:0] comp_nxt;

  assign upd_ready = 1'b1;
  assign fire      = upd_valid && upd_ready;
  assign dir       = chg_mode ? DIR_CHARGE : DIR_DISCHARGE;

  chg_trk_comp #(.CHG_W(CHG_W)) u_comp (
    .clk(clk), .rst(rst), .fire(fire), .dir(dir),
    .raw(raw_chg), .rate(rate_chg),
    .comp_q(comp_chg), .comp_nxt(comp_nxt)
  );

  chg_trk_temp #(.CHG_W(CHG_W)) u_temp (
    .clk(clk), .rst(rst), .fire(fire), .cold(cold),
    .raw(raw_chg), .comp_nxt(comp_nxt), .derate(derate),
    .temp_q(temp_chg)
  );

  a_r10_temp_le_comp: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (temp_chg <= comp_chg));

  a_r7_warm_copy: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !cold) |=> (temp_chg == comp_chg));
endmodule

// File: tb/tb_chg_trk_top.sv
`timescale 1ns/1ps
module tb_chg_trk_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst;
  logic         upd_valid, upd_ready, chg_mode, cold;
  logic [W-1:0] raw_chg, rate_chg, derate, comp_chg, temp_chg;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] m_comp, m_temp;

  always #5 clk = ~clk;

  chg_trk_top #(.CHG_W(W)) dut (
    .clk(clk), .rst(rst), .upd_valid(upd_valid), .upd_ready(upd_ready),
    .chg_mode(chg_mode), .cold(cold), .raw_chg(raw_chg), .rate_chg(rate_chg),
    .derate(derate), .comp_chg(comp_chg), .temp_chg(temp_chg)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] f_comp(input logic v, input logic m,
      input logic [W-1:0] cur, input logic [W-1:0] raw, input logic [W-1:0] rate);
    if (!v) return cur;
    if (m) return raw;
    return (rate < cur) ? rate : cur;
  endfunction

  function automatic logic [W-1:0] f_temp(input logic v, input logic c,
      input logic [W-1:0] cur, input logic [W-1:0] nc, input logic [W-1:0] d);
    if (!v) return cur;
    if (!c) return nc;
    return (d >= nc) ? '0 : nc - d;
  endfunction

  task automatic step(input logic v, input logic m, input logic c,
      input logic [W-1:0] raw, input logic [W-1:0] rate, input logic [W-1:0] d);
    logic [W-1:0] nc, nt, prev;
    string rc, rt;
    upd_valid = v; chg_mode = m; cold = c;
    raw_chg = raw; rate_chg = rate; derate = d;
    prev = m_comp;
    nc = f_comp(v, m, m_comp, raw, rate);
    nt = f_temp(v, c, m_temp, nc, d);
    if (!v)               rc = "R2";
    else if (m)           rc = "R6";
    else if (rate < prev) rc = "R3";
    else                  rc = "R4";
    if (!v)               rt = "R2";
    else if (!c)          rt = "R7";
    else if (d >= nc)     rt = "R9";
    else                  rt = "R8";
    chk("R11", {15'd0, upd_ready}, 16'd1);
    @(posedge clk); #1;
    m_comp = nc; m_temp = nt;
    chk(rc, comp_chg, m_comp);
    chk(rt, temp_chg, m_temp);
    chk("R10", {15'd0, temp_chg > comp_chg}, 16'd0);
    if (v && !m) chk("R5", {15'd0, comp_chg > prev}, 16'd0);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] r;
    void'($urandom(32'd20241));
    rst = 1'b1; upd_valid = 0; chg_mode = 0; cold = 0;
    raw_chg = 16'h1234; rate_chg = 16'h0000; derate = 16'h0000;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", comp_chg, 16'h1234);
    chk("R1", temp_chg, 16'h1234);
    raw_chg = 16'h5000;
    @(posedge clk); #1;
    chk("R1", comp_chg, 16'h5000);
    chk("R1", temp_chg, 16'h5000);
    rst = 1'b0;
    m_comp = 16'h5000; m_temp = 16'h5000;

    step(0, 0, 0, 16'h0100, 16'h0010, 16'h0);   // R2: no beat, hold
    step(1, 0, 0, 16'h4F00, 16'h4000, 16'h0);   // R3 lower loads
    step(1, 0, 0, 16'h4F00, 16'h4000, 16'h0);   // R4 equal ignored
    step(1, 0, 0, 16'hFFFF, 16'h4800, 16'h0);   // R4 higher ignored
    step(1, 0, 1, 16'h0, 16'h3000, 16'h0100);   // R8 derated
    step(1, 0, 1, 16'h0, 16'h3000, 16'h3000);   // R9 derate equals
    step(1, 0, 1, 16'h0, 16'h3000, 16'hFFFF);   // R9 derate exceeds
    step(0, 1, 0, 16'h7000, 16'h0, 16'h0);      // R2 hold with cold zero
    step(1, 1, 0, 16'h7000, 16'h0, 16'h0);      // R6 up
    step(1, 1, 0, 16'h0200, 16'hFFFF, 16'h0);   // R6 down
    step(1, 1, 1, 16'h0000, 16'h0, 16'h0000);   // R9 zero comp

    for (int i = 0; i < 3000; i++) begin
      logic v, m, c;
      logic [W-1:0] raw, rate, d;
      v = ($urandom % 4) != 0;
      m = ($urandom % 6) == 0;
      c = $urandom % 2;
      raw = $urandom;
      r = $urandom % 9;
      rate = m_comp + r - 16'd4;
      if (($urandom % 3) == 0) rate = $urandom;
      d = ($urandom % 2) ? W'($urandom % 64) : m_comp + W'($urandom % 3) - 16'd1;
      step(v, m, c, raw, rate, d);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule